// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block sits in the target clock domain and plays the part of a processor's external bus. A bus-cycle command comes in over a valid/ready stream from the host-side logic. The block then drives address strobe, read/write and memory/special qualifiers, lock and the data bus in a fixed order, so the target sees a genuine non-pipelined processor cycle. It waits for the target's active-low ready input, captures the read data and returns one response per command on a second valid/ready stream.

Four cycle kinds are supported: a single read, a single write, a locked read-then-write to one address, and an interrupt acknowledge made of two special cycles. A watchdog aborts any data phase the target never completes. A plain status word, separate from the response path, always shows the block's own state and the target's ready line.

Back-pressure rules: a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when the block is idle with no response pending. A response stays valid and unchanged until it is taken on an edge with `rsp_ready` high. The host must keep a command stable while `cmd_valid` is high and `cmd_ready` is low.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset `bus_strb_n` and `bus_lock_n` are 1, `bus_doe` is 0, `bus_addr` is 0, `cmd_ready` is 1, `rsp_valid` is 0 and `status` is 0.
- R2: A command is accepted on an edge with `cmd_valid` and `cmd_ready` high. `cmd_ready` then stays 0 until the response has been taken, and it is 1 again in the cycle after that.
- R3: Each transfer opens with an address phase one clock long. In the cycle after acceptance, or after the ready of the previous transfer in a two-transfer sequence, `bus_strb_n` is 0 and `bus_addr` holds the command address. `bus_write` is 1 for a write transfer. `bus_mem` is 1 for memory transfers and 0 for special cycles. In the next cycle `bus_strb_n` is 1 again.
- R4: The data phase lasts until an edge where `bus_rdy_n` is 0. Ready seen during the address phase is ignored. Read data is taken from `bus_din` on that edge, and for the last transfer `rsp_valid` is 1 in the next cycle.
- R5: Kind encoding: 0 read, 1 write, 2 locked, 3 interrupt acknowledge. For a write transfer `bus_doe` is 1 and `bus_dout` equals the command write data from the address phase until the ready edge. `bus_doe` is 0 for all other transfers. A write returns response data 0.
- R6: A locked command runs a read and then a write to the same address. `bus_lock_n` is 0 from the first address phase until the ready of the write, and 1 in the cycle after it. The response carries the data read.
- R7: An interrupt acknowledge runs two special read cycles (`bus_mem`=0, `bus_write`=0). The response is bits 7:0 of `bus_din` at the second ready, zero-extended. Data at the first ready is discarded.
- R8: If `TMO` (default 255) data-phase clocks pass without ready, the command is aborted. `rsp_valid` is 1 with `rsp_tmo`=1 and `rsp_data`=0, and lock is released. Status bit 3 is set and stays set until the next command is accepted.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_tmo` hold their values.
- R10: Status bits: bit 0 is the inverted `bus_rdy_n` as registered on the last edge; bit 1 is 1 from acceptance until the response is ready; bit 2 is 1 while lock is held; bit 3 is the sticky timeout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_kind | input | 2 | Cycle kind (0 read, 1 write, 2 locked, 3 interrupt ack) |
| cmd_addr | input | AW | Transfer address |
| cmd_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | DW | Read data or vector |
| rsp_tmo | output | 1 | Command aborted by watchdog |
| status | output | 4 | Block and target status word |
| bus_strb_n | output | 1 | Address strobe, active low |
| bus_addr | output | AW | Bus address |
| bus_write | output | 1 | 1 for a write transfer |
| bus_mem | output | 1 | 1 for a memory transfer, 0 for a special cycle |
| bus_lock_n | output | 1 | Bus lock, active low |
| bus_dout | output | DW | Data driven to the target |
| bus_doe | output | 1 | Data bus drive enable |
| bus_din | input | DW | Data from the target |
| bus_rdy_n | input | 1 | Target ready, active low |

## Verification
The bench applies all stimulus on falling edges and samples there too. The address phase of each transfer is checked one cycle after acceptance or after the previous ready. The strobe is checked to be released one cycle later. A response is checked exactly one cycle after the final ready edge. The watchdog case counts falling edges from the first data-phase cycle and expects the aborted response on the `TMO`-th. Response back-pressure is checked on every held cycle. After the response is taken, the return of `cmd_ready` and the clearing of `rsp_valid` are checked in the following cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    K_RD   = 2'd0,
    K_WR   = 2'd1,
    K_LOCK = 2'd2,
    K_INTA = 2'd3
  } kind_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ADDR = 2'd1,
    S_DATA = 2'd2,
    S_RESP = 2'd3
  } phase_t;

  localparam int STAT_W = 4;
endpackage

// File: rtl/bcs_watchdog.sv
module bcs_watchdog #(
  parameter int TMO = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rdy,
  output logic expire
);
  localparam int CW = $clog2(TMO + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run || rdy || expire) cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end

  assign expire = run && !rdy && (cnt == LAST);

  // R8
  wdog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/bcs_rsp.sv
module bcs_rsp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap_en,
  input  logic [DW-1:0] cap_val,
  input  logic          fin,
  input  logic          fin_tmo,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_tmo
);
  logic [DW-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_tmo   <= 1'b0;
    end else begin
      if (clr)         held <= '0;
      else if (cap_en) held <= cap_val;
      if (fin) begin
        rsp_valid <= 1'b1;
        rsp_tmo   <= fin_tmo;
        rsp_data  <= fin_tmo ? '0 : (cap_en ? cap_val : held);
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_tmo)));
endmodule

// File: rtl/bcs_status.sv
module bcs_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       lock_held,
  input  logic       tmo_set,
  input  logic       tmo_clr,
  input  logic       bus_rdy_n,
  output logic [3:0] status
);
  logic rdy_seen;
  logic tmo_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_seen <= 1'b0;
      tmo_flag <= 1'b0;
    end else begin
      rdy_seen <= !bus_rdy_n;
      if (tmo_set)      tmo_flag <= 1'b1;
      else if (tmo_clr) tmo_flag <= 1'b0;
    end
  end

  assign status = {tmo_flag, lock_held, busy, rdy_seen};

  // R8
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !tmo_clr) |=> tmo_flag);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int TMO = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_tmo,
  output logic [3:0]    status,
  output logic          bus_strb_n,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic          bus_mem,
  output logic          bus_lock_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_rdy_n
);
  localparam int VW = 8;

  phase_t        state;
  kind_t         kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          step_q;
  logic          lock_q;

  logic cmd_fire, rdy, in_data, last_xfer, done_ok, expire, fin;
  logic cap_en, cur_write;
  logic [DW-1:0] cap_val;

  assign cmd_ready = (state == S_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign rdy       = !bus_rdy_n;
  assign in_data   = (state == S_DATA);
  assign last_xfer = (kind_q == K_RD) || (kind_q == K_WR) || step_q;
  assign done_ok   = in_data && rdy && last_xfer;
  assign fin       = done_ok || expire;
  assign cur_write = (kind_q == K_WR) || ((kind_q == K_LOCK) && step_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      kind_q  <= K_RD;
      addr_q  <= '0;
      wdata_q <= '0;
      step_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (cmd_fire) begin
          state   <= S_ADDR;
          kind_q  <= kind_t'(cmd_kind);
          addr_q  <= cmd_addr;
          wdata_q <= cmd_wdata;
          step_q  <= 1'b0;
          lock_q  <= (kind_t'(cmd_kind) == K_LOCK);
        end
        S_ADDR: state <= S_DATA;
        S_DATA: begin
          if (fin) begin
            state  <= S_RESP;
            lock_q <= 1'b0;
          end else if (rdy) begin
            state  <= S_ADDR;
            step_q <= 1'b1;
          end
        end
        S_RESP: if (rsp_valid && rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cap_en  = in_data && rdy &&
              ((kind_q == K_RD) ||
               ((kind_q == K_LOCK) && !step_q) ||
               ((kind_q == K_INTA) && step_q));
    cap_val = (kind_q == K_INTA) ? {{(DW-VW){1'b0}}, bus_din[VW-1:0]} : bus_din;
  end

  assign bus_strb_n = !(state == S_ADDR);
  assign bus_addr   = addr_q;
  assign bus_write  = cur_write && ((state == S_ADDR) || in_data);
  assign bus_mem    = (kind_q != K_INTA);
  assign bus_lock_n = !lock_q;
  assign bus_doe    = bus_write;
  assign bus_dout   = wdata_q;

  bcs_watchdog #(.TMO(TMO)) i_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (in_data),
    .rdy    (rdy),
    .expire (expire)
  );

  bcs_rsp #(.DW(DW)) i_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cmd_fire),
    .cap_en    (cap_en),
    .cap_val   (cap_val),
    .fin       (fin),
    .fin_tmo   (expire),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_tmo   (rsp_tmo)
  );

  bcs_status i_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      ((state == S_ADDR) || in_data),
    .lock_held (lock_q),
    .tmo_set   (expire),
    .tmo_clr   (cmd_fire),
    .bus_rdy_n (bus_rdy_n),
    .status    (status)
  );

  // R3
  strb_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strb_n |=> bus_strb_n);

  // R3
  strb_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !bus_strb_n);

  // R6
  lock_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && kind_q == K_LOCK && !step_q && rdy && !expire) |=> !bus_lock_n);

  // R2
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_strb_n || rsp_valid) |-> !cmd_ready);
endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int TMO = 255;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_kind = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [DW-1:0] rsp_data;
  logic          rsp_tmo;
  logic [3:0]    status;
  logic          bus_strb_n;
  logic [AW-1:0] bus_addr;
  logic          bus_write;
  logic          bus_mem;
  logic          bus_lock_n;
  logic [DW-1:0] bus_dout;
  logic          bus_doe;
  logic [DW-1:0] bus_din = '0;
  logic          bus_rdy_n = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bus_cycle_seq #(.AW(AW), .DW(DW), .TMO(TMO)) i_bus_cycle_seq (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [DW-1:0] exp_data(input logic [1:0] k, input logic [DW-1:0] d1,
                                             input logic [DW-1:0] d2);
    case (k)
      2'd0:    return d1;
      2'd1:    return '0;
      2'd2:    return d1;
      default: return {{(DW-8){1'b0}}, d2[7:0]};
    endcase
  endfunction

  // Called at the falling edge where the address phase should be visible.
  task automatic xfer(input logic [AW-1:0] a, input bit wr, input bit mem, input bit lk,
                      input logic [DW-1:0] wd, input int dly, input logic [DW-1:0] din,
                      input bit ign);
    chk(bus_strb_n == 1'b0, "R3", "strobe low", 64'(bus_strb_n), 0);
    chk(bus_addr == a, "R3", "address", 64'(bus_addr), 64'(a));
    chk(bus_write == wr, "R3", "write qualifier", 64'(bus_write), 64'(wr));
    chk(bus_mem == mem, "R3", "memory qualifier", 64'(bus_mem), 64'(mem));
    chk(bus_lock_n == !lk, "R6", "lock in address phase", 64'(bus_lock_n), 64'(!lk));
    chk(bus_doe == wr, "R5", "drive enable addr phase", 64'(bus_doe), 64'(wr));
    if (wr) chk(bus_dout == wd, "R5", "write data", 64'(bus_dout), 64'(wd));
    chk(status[1] == 1'b1, "R10", "busy bit", 64'(status), 2);
    bus_rdy_n = ign ? 1'b0 : 1'b1;   // R4: ready in address phase must be ignored
    @(negedge clk);
    chk(bus_strb_n == 1'b1, "R3", "strobe one clock", 64'(bus_strb_n), 1);
    for (int i = 0; i < dly; i++) begin
      bus_rdy_n = 1'b1;
      chk(bus_doe == wr, "R5", "drive enable data phase", 64'(bus_doe), 64'(wr));
      chk(rsp_valid == 1'b0, "R4", "no early response", 64'(rsp_valid), 0);
      @(negedge clk);
    end
    chk(bus_doe == wr, "R5", "drive enable at ready", 64'(bus_doe), 64'(wr));
    chk(bus_lock_n == !lk, "R6", "lock in data phase", 64'(bus_lock_n), 64'(!lk));
    bus_rdy_n = 1'b0;
    bus_din   = din;
    @(negedge clk);
    bus_rdy_n = 1'b1;
    bus_din   = $urandom;
  endtask

  task automatic take_rsp(input int hold, input logic [DW-1:0] ed, input bit et);
    for (int i = 0; i < hold; i++) begin
      chk(rsp_valid && rsp_data == ed && rsp_tmo == et, "R9", "response held",
          64'(rsp_data), 64'(ed));
      chk(cmd_ready == 1'b0, "R2", "not ready while response pending", 64'(cmd_ready), 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0, "R9", "response taken", 64'(rsp_valid), 0);
    chk(cmd_ready == 1'b1, "R2", "ready after response", 64'(cmd_ready), 1);
  endtask

  task automatic run_cmd(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input int d1, input int d2, input logic [DW-1:0] din1,
                         input logic [DW-1:0] din2, input bit ign, input int hold);
    logic [DW-1:0] ed;
    cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_addr = $urandom; cmd_wdata = $urandom;
    chk(cmd_ready == 1'b0, "R2", "busy after accept", 64'(cmd_ready), 0);
    chk(status[3] == 1'b0, "R8", "timeout flag cleared on accept", 64'(status), 0);
    chk(status[2] == (k == 2'd2), "R10", "lock status bit", 64'(status), 64'(k == 2'd2));
    xfer(a, k == 2'd1, k != 2'd3, k == 2'd2, wd, d1, din1, ign);
    if (k == 2'd2) xfer(a, 1'b1, 1'b1, 1'b1, wd, d2, din2, 1'b0);     // R6 second transfer
    if (k == 2'd3) xfer(a, 1'b0, 1'b0, 1'b0, wd, d2, din2, ign);      // R7 second cycle
    ed = exp_data(k, din1, din2);
    chk(rsp_valid == 1'b1, "R4", "response one cycle after ready", 64'(rsp_valid), 1);
    chk(rsp_data == ed, (k == 2'd3) ? "R7" : (k == 2'd2) ? "R6" : "R4", "response data",
        64'(rsp_data), 64'(ed));
    chk(rsp_tmo == 1'b0, "R8", "no timeout", 64'(rsp_tmo), 0);
    chk(bus_lock_n == 1'b1, "R6", "lock released", 64'(bus_lock_n), 1);
    chk(bus_doe == 1'b0, "R5", "drive released", 64'(bus_doe), 0);
    chk(status == 4'b0001, "R10", "status after ready", 64'(status), 1);
    take_rsp(hold, ed, 1'b0);
  endtask

  task automatic run_timeout(input logic [1:0] k, input logic [AW-1:0] a);
    int n;
    cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a; cmd_wdata = $urandom;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(bus_strb_n == 1'b0, "R3", "strobe before timeout", 64'(bus_strb_n), 0);
    bus_rdy_n = 1'b1;
    @(negedge clk);
    n = 0;
    while (!rsp_valid && n < TMO + 5) begin
      chk(bus_lock_n == (k != 2'd2), "R6", "lock while waiting", 64'(bus_lock_n),
          64'(k != 2'd2));
      @(negedge clk);
      n++;
    end
    chk(n == TMO, "R8", "timeout cycle count", 64'(n), 64'(TMO));
    chk(rsp_tmo == 1'b1 && rsp_data == '0, "R8", "timeout response", 64'(rsp_data), 0);
    chk(bus_lock_n == 1'b1, "R8", "lock released on abort", 64'(bus_lock_n), 1);
    chk(status == 4'b1000, "R8", "timeout status", 64'(status), 8);
    take_rsp(1, '0, 1'b1);
    chk(status[3] == 1'b1, "R8", "timeout flag sticky", 64'(status), 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual running expected done");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(bus_strb_n == 1'b1 && bus_lock_n == 1'b1 && bus_doe == 1'b0, "R1", "bus idle",
        64'({bus_strb_n, bus_lock_n, bus_doe}), 64'b110);
    chk(bus_addr == '0, "R1", "address zero", 64'(bus_addr), 0);
    chk(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R1", "handshake idle",
        64'({cmd_ready, rsp_valid}), 64'b10);
    chk(status == 4'b0000, "R1", "status zero", 64'(status), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_cmd(2'd0, 32'h0000_1000, 32'h0, 0, 0, 32'hdead_beef, 32'h0, 1'b1, 0);  // R4 ready ignored
    run_cmd(2'd1, 32'h0000_2004, 32'hcafe_f00d, 3, 0, 32'h1111_1111, 32'h0, 1'b0, 2); // R5
    run_cmd(2'd2, 32'h0000_3008, 32'h5a5a_a5a5, 2, 4, 32'h1234_5678, 32'h9999_0000, 1'b0, 3); // R6
    run_cmd(2'd3, 32'h0000_0000, 32'h0, 1, 2, 32'h0000_00aa, 32'hffff_ff42, 1'b1, 1); // R7
    run_timeout(2'd2, 32'h0000_4000);  // R8 locked abort
    run_cmd(2'd0, 32'h0000_5000, 32'h0, 0, 0, 32'h0bad_cafe, 32'h0, 1'b0, 0); // clears flag
    run_timeout(2'd0, 32'h0000_6000);  // R8 read abort

    // random mix
    for (int it = 0; it < 40; it++) begin
      run_cmd(2'($urandom_range(0, 3)), $urandom, $urandom,
              $urandom_range(0, 6), $urandom_range(0, 6), $urandom, $urandom,
              1'($urandom_range(0, 1)), $urandom_range(0, 3));
    end
    summary();
  end
endmodule